// File: doc/BRIEF.md
# Three-Phase Commutation Track Generator

This block turns a 12-bit absolute mechanical shaft angle into three square-wave commutation tracks, U, V and W, for driving the phases of a brushless motor. The three tracks have the same shape and are spaced a third of an electrical period apart. One configuration bit picks whether the electrical pattern repeats once per mechanical turn (two-pole motor) or twice (four-pole motor).

An 8-bit zero code moves the rising edge of U around the revolution. The code selects one of 192 evenly spaced positions. Codes at 0xC0 and above fold back onto positions that lower codes already reach.

The path is purely arithmetic. The block applies the offset, scales to electrical angle and compares against three phase thresholds. Its only state is a single output register, so the tracks follow the angle with a latency of one clock.

Top module: `commutation_gen`

## Requirements
- R1: While the active-low reset is low, U, V and W are all 0. This holds from the first clock edge in reset, and also when reset is applied in the middle of operation.
- R2: U, V and W are registered. Their values after a rising clock edge come from the angle, pole bit and zero code sampled at that edge, and they do not change between edges.
- R3: With zero code 0 and pole bit 0, U is 1 exactly for angles 0 to 2047 and 0 for angles 2048 to 4095.
- R4: V follows U's rule with the electrical angle reduced by 1365 (modulo 4096). W follows the same rule with the electrical angle reduced by 2730. A track is 1 when its reduced angle is below 2048.
- R5: With pole bit 0, the electrical angle is the offset-shifted mechanical angle, so the track pattern occurs once per revolution.
- R6: With pole bit 1, the electrical angle is twice the offset-shifted angle, modulo 4096, so the pattern occurs twice per revolution.
- R7: A zero code c below 192 is converted to the angle floor(c*4096/192). That angle is subtracted from the input angle modulo 4096, so code 0 gives no shift and code 191 gives a shift of 4074.
- R8: A zero code c of 192 or above acts exactly as code c-80, so 0xC0 acts as 0x70 and 0xFF acts as 0xAF.
- R9: From the first update after reset, the tracks never show 000 or 111.
- R10: When the angle moves by +1 between consecutive clocks and the configuration is unchanged, at most one track toggles.
- R11: While the angle, pole bit and zero code are held constant, the tracks stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| angle_i | input | 12 | Absolute mechanical angle, 4096 steps per turn |
| four_pole_i | input | 1 | 0: pattern once per turn, 1: twice per turn |
| zero_code_i | input | 8 | Position code for the rising edge of U |
| u_o | output | 1 | Commutation track U |
| v_o | output | 1 | Commutation track V, one third period after U |
| w_o | output | 1 | Commutation track W, two thirds period after U |

## Verification
A wrong offset conversion, fold or doubling moves one of the six track edges. It therefore shows at the ports in the very cycle after the first angle that lands between the true and the wrong edge. Sweeping every angle in both pole modes, together with every zero code over a grid of angles, exposes any misplaced edge on the next clock. A stuck or mis-timed output register shows at once as a track that ignores reset, lags by an extra cycle, or changes while its inputs are held.

// File: rtl/comm_pkg.sv
package comm_pkg;

    // Bit positions of the three tracks inside the packed track vector.
    localparam int TRK_U = 0;
    localparam int TRK_V = 1;
    localparam int TRK_W = 2;
    localparam int NUM_TRACKS = 3;

    typedef logic [NUM_TRACKS-1:0] tracks_t;

endpackage

// File: rtl/comm_offset_fold.sv
// Maps zero codes beyond the valid range back onto earlier positions.
module comm_offset_fold #(
    parameter int OFF_W      = 8,
    parameter int FOLD_START = 192,
    parameter int FOLD_SHIFT = 80
) (
    input  logic [OFF_W-1:0] code_i,
    output logic [OFF_W-1:0] code_o
);
    localparam logic [OFF_W-1:0] START_C = OFF_W'(FOLD_START);
    localparam logic [OFF_W-1:0] SHIFT_C = OFF_W'(FOLD_SHIFT);

    always_comb begin
        if (code_i >= START_C) begin
            code_o = code_i - SHIFT_C;
        end else begin
            code_o = code_i;
        end
    end
endmodule

// File: rtl/comm_offset_angle.sv
// Converts a position code into an angle: floor(code * 2^ANGLE_W / STEPS).
module comm_offset_angle #(
    parameter int OFF_W   = 8,
    parameter int ANGLE_W = 12,
    parameter int STEPS   = 192
) (
    input  logic [OFF_W-1:0]   code_i,
    output logic [ANGLE_W-1:0] angle_o
);
    localparam int PROD_W = OFF_W + ANGLE_W;
    localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(STEPS);

    logic [PROD_W-1:0] scaled;

    always_comb begin
        scaled  = {code_i, {ANGLE_W{1'b0}}};
        angle_o = ANGLE_W'(scaled / DIVISOR);
    end
endmodule

// File: rtl/comm_elec_angle.sv
// Shifts the mechanical angle by the offset and scales it to electrical angle.
module comm_elec_angle #(
    parameter int ANGLE_W = 12
) (
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic [ANGLE_W-1:0] offset_i,
    input  logic               four_pole_i,
    output logic [ANGLE_W-1:0] elec_o
);
    logic [ANGLE_W-1:0] shifted;
    logic [ANGLE_W-1:0] doubled;

    always_comb begin
        shifted = angle_i - offset_i;
        doubled = {shifted[ANGLE_W-2:0], 1'b0};
        elec_o  = four_pole_i ? doubled : shifted;
    end
endmodule

// File: rtl/comm_track_decode.sv
// Each track k is high while (elec - k*FULL/NUM) mod FULL is in the lower half.
module comm_track_decode
    import comm_pkg::*;
#(
    parameter int ANGLE_W = 12
) (
    input  logic [ANGLE_W-1:0] elec_i,
    output tracks_t            tracks_o
);
    localparam int FULL = 1 << ANGLE_W;

    for (genvar k = 0; k < NUM_TRACKS; k++) begin : g_track
        localparam logic [ANGLE_W-1:0] PHASE = ANGLE_W'((k * FULL) / NUM_TRACKS);
        logic [ANGLE_W-1:0] rel;
        assign rel         = elec_i - PHASE;
        assign tracks_o[k] = ~rel[ANGLE_W-1];
    end
endmodule

// File: rtl/commutation_gen.sv
module commutation_gen
    import comm_pkg::*;
#(
    parameter int ANGLE_W    = 12,
    parameter int OFF_W      = 8,
    parameter int STEPS      = 192,
    parameter int FOLD_START = 192,
    parameter int FOLD_SHIFT = 80
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               four_pole_i,
    input  logic [OFF_W-1:0]   zero_code_i,
    output logic               u_o,
    output logic               v_o,
    output logic               w_o
);
    localparam logic [1:0] AGE_MAX = 2'd2;

    typedef struct packed {
        tracks_t    tracks;
        logic [1:0] age;     // updates since reset, saturating; used by checks
    } state_t;

    logic [OFF_W-1:0]   code_folded;
    logic [ANGLE_W-1:0] offset_angle;
    logic [ANGLE_W-1:0] elec_angle;
    tracks_t            tracks_comb;
    state_t             state_d, state_q;

    comm_offset_fold #(
        .OFF_W      (OFF_W),
        .FOLD_START (FOLD_START),
        .FOLD_SHIFT (FOLD_SHIFT)
    ) i_fold (
        .code_i (zero_code_i),
        .code_o (code_folded)
    );

    comm_offset_angle #(
        .OFF_W   (OFF_W),
        .ANGLE_W (ANGLE_W),
        .STEPS   (STEPS)
    ) i_offset (
        .code_i  (code_folded),
        .angle_o (offset_angle)
    );

    comm_elec_angle #(
        .ANGLE_W (ANGLE_W)
    ) i_elec (
        .angle_i     (angle_i),
        .offset_i    (offset_angle),
        .four_pole_i (four_pole_i),
        .elec_o      (elec_angle)
    );

    comm_track_decode #(
        .ANGLE_W (ANGLE_W)
    ) i_decode (
        .elec_i   (elec_angle),
        .tracks_o (tracks_comb)
    );

    always_comb begin
        state_d        = state_q;
        state_d.tracks = tracks_comb;
        if (state_q.age != AGE_MAX) begin
            state_d.age = state_q.age + 2'd1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign u_o = state_q.tracks[TRK_U];
    assign v_o = state_q.tracks[TRK_V];
    assign w_o = state_q.tracks[TRK_W];

    // R1: reset forces all tracks low
    assert_reset_low_R1: assert property (@(posedge clk_i)
        !rst_ni |=> ({u_o, v_o, w_o} == 3'b000));

    // R9: no all-equal pattern once running
    assert_no_flat_pattern_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.age != 2'd0) |-> ({u_o, v_o, w_o} != 3'b000 && {u_o, v_o, w_o} != 3'b111));

    // R10: unit angle step toggles at most one track
    assert_single_toggle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.age == AGE_MAX) && (ANGLE_W'(angle_i - $past(angle_i)) == ANGLE_W'(1))
        && $stable(four_pole_i) && $stable(zero_code_i)
        |=> ($countones({u_o, v_o, w_o} ^ $past({u_o, v_o, w_o})) <= 1));

    // R11: held inputs give held outputs
    assert_hold_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q.age == AGE_MAX) && $stable(angle_i) && $stable(four_pole_i)
        && $stable(zero_code_i) |=> $stable({u_o, v_o, w_o}));
endmodule

// File: tb/test_commutation_gen.sv
`timescale 1ns/1ps
module test_commutation_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] angle = '0;
    logic        pole = 1'b0;
    logic [7:0]  code = '0;
    logic        u, v, w;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    commutation_gen i_commutation_gen (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .angle_i     (angle),
        .four_pole_i (pole),
        .zero_code_i (code),
        .u_o         (u),
        .v_o         (v),
        .w_o         (w)
    );

    // Reference built from the requirements: returns {w, v, u}.
    function automatic logic [2:0] ref_tracks(input int a, input int p, input int c);
        int fc, offa, sh, e;
        logic [2:0] r;
        fc   = (c >= 192) ? c - 80 : c;
        offa = (fc * 4096) / 192;
        sh   = (a - offa + 4096) % 4096;
        e    = (p != 0) ? (sh * 2) % 4096 : sh;
        r[0] = (e < 2048);
        r[1] = (((e - 1365 + 4096) % 4096) < 2048);
        r[2] = (((e - 2730 + 4096) % 4096) < 2048);
        return r;
    endfunction

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s angle=%0d pole=%0d code=%0d actual(wvu)=%b expected(wvu)=%b",
                     req, angle, pole, code, act, exp);
        end
    endtask

    task automatic apply_check(input string req, input int a, input int p, input int c);
        @(negedge clk);
        angle = 12'(a);
        pole  = p[0];
        code  = 8'(c);
        @(negedge clk);
        check(req, {w, v, u}, ref_tracks(a, p, c));
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [2:0] prev, cur, first;
        // R1: reset holds outputs low even for an angle that sets U and W
        repeat (3) @(negedge clk);
        check("R1", {w, v, u}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        // R2/R3: first update reflects angle 0 -> U=1 V=0 W=1
        check("R2", {w, v, u}, 3'b101);

        // R2: output changes only after the next rising edge
        angle = 12'd2048;
        #2;
        check("R2", {w, v, u}, 3'b101);
        @(negedge clk);
        check("R2", {w, v, u}, ref_tracks(2048, 0, 0));

        // R3/R4/R5/R9/R10: full sweep, two-pole, no offset
        apply_check("R3", 0, 0, 0);
        prev = {w, v, u};
        for (int a = 1; a < 4096; a++) begin
            apply_check("R4_R5", a, 0, 0);
            cur = {w, v, u};
            n_cmp++;
            if ($countones(cur ^ prev) > 1 || cur == 3'b000 || cur == 3'b111) begin
                n_bad++;
                $display("FAIL R10_R9 angle=%0d actual=%b previous=%b expected at most one toggle",
                         a, cur, prev);
            end
            prev = cur;
        end

        // R6: full sweep, four-pole, no offset
        for (int a = 0; a < 4096; a++) begin
            apply_check("R6", a, 1, 0);
        end

        // R7/R8: every code over a grid of angles in both modes
        for (int c = 0; c < 256; c++) begin
            for (int a = 0; a < 4096; a += 331) begin
                apply_check((c >= 192) ? "R8" : "R7", a, c % 2, c);
            end
        end

        // R7: edge of U with code 191 sits at angle 4074
        apply_check("R7", 4073, 0, 191);
        apply_check("R7", 4074, 0, 191);

        // R8: folded code gives identical outputs to code - 80
        for (int c = 192; c < 256; c += 9) begin
            for (int a = 100; a < 4096; a += 700) begin
                apply_check("R8", a, 0, c);
                first = {w, v, u};
                apply_check("R8", a, 0, c - 80);
                check("R8", {w, v, u}, first);
            end
        end

        // R11: held inputs keep outputs constant
        apply_check("R11", 1234, 1, 17);
        first = {w, v, u};
        repeat (6) begin
            @(negedge clk);
            check("R11", {w, v, u}, first);
        end

        // R1: mid-run reset clears outputs at once and on following edges
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", {w, v, u}, 3'b000);
        @(negedge clk);
        check("R1", {w, v, u}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2", {w, v, u}, ref_tracks(1234, 1, 17));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule